// File: doc/BRIEF.md
# Periodic Interrupt Rate Generator

This block divides a reference tick into a programmable periodic rate. It drives a square-wave pin and sets a periodic flag on each rising edge of that rate. A 4-bit rate code selects one of fifteen frequencies, each half of the one before, or turns the periodic output off.

Two further event inputs, an alarm match and an end-of-update pulse, set their own flags. The three flags sit in a flag register together with a summary bit. That bit is high when any flag is set and its enable is also set. The interrupt request pin follows the summary bit. Reading the flag register returns the flags and clears them.

Software reaches three byte-wide registers through a simple port: a rate register, a control register holding the enables, and the read-only flag register. With a reference tick of 65536 Hz, rate code n gives 65536 >> n Hz, so code 6 is 1024 Hz.

Top module: `periodic_rate_gen`

## Requirements
- R1: After reset the rate code is 0, all enables are 0, all flags are 0, and `sqw_out`, `irq_out` and the read data are all 0.
- R2: Register select 0 is the rate register. Write bits 3:0 hold the rate code, and bits 7:4 read back as 0. Read data appears on `reg_rdata` one clock after `reg_rd` and holds until the next read.
- R3: Register select 1 is the control register. Bit 6 enables the periodic interrupt, bit 5 the alarm interrupt, bit 4 the update interrupt and bit 3 the square wave. All other bits read back as 0.
- R4: A 15-bit counter, cleared by reset, advances once per `ref_tick` cycle. For rate code n from 1 to 15 with the square wave enabled, `sqw_out` equals counter bit n-1, which gives a period of 2^n ticks.
- R5: `sqw_out` is held low when the square-wave enable is 0 or the rate code is 0.
- R6: The periodic flag sets on the tick that drives the selected counter bit from 0 to 1, whether or not the periodic enable is set. Rate code 0 never sets it. Once set, it stays set until the flag register is read.
- R7: Register select 2 reads as {summary, periodic, alarm, update, 4'b0000} in bits 7 down to 0. A pulse on `alarm_evt` sets the alarm flag and a pulse on `update_evt` sets the update flag, whatever the enables.
- R8: The summary bit and `irq_out` are 1 exactly when at least one flag is set together with its enable bit.
- R9: Reading the flag register returns the flag values held before the read and clears all three flags.
- R10: A flag whose event arrives in the same cycle as a flag-register read is not cleared. It is reported by the next read.
- R11: Writes to register select 2 change no register and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick | input | 1 | One-cycle pulse at the reference rate |
| alarm_evt | input | 1 | Alarm match pulse |
| update_evt | input | 1 | Update-complete pulse |
| reg_sel | input | 2 | Register select: 0 rate, 1 control, 2 flags |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| sqw_out | output | 1 | Square-wave output |
| irq_out | output | 1 | Interrupt request, active high |

## Verification
A flag-setting event can fall in the same clock cycle as the read that clears the flag register. The bench provokes this with rate code 1, where the counter parity makes the periodic edge land on a known tick. It then issues a tick and a flag-register read together, and does the same with an alarm pulse. It expects that read to return the flag clear, and the following read to return the flag set. A full sweep of all fifteen rate codes checks the square wave against counter arithmetic after every tick.

// File: rtl/prg_pkg.sv
package prg_pkg;
    localparam int RATE_W = 4;
    localparam int DIV_W  = (1 << RATE_W) - 1;
    localparam int DATA_W = 8;
    localparam int SEL_W  = 2;

    // control register bit positions
    localparam int CTL_PIE  = 6;
    localparam int CTL_AIE  = 5;
    localparam int CTL_UIE  = 4;
    localparam int CTL_SQWE = 3;

    // flag register bit positions
    localparam int FLG_SUM = 7;
    localparam int FLG_PF  = 6;
    localparam int FLG_AF  = 5;
    localparam int FLG_UF  = 4;

    typedef enum logic [SEL_W-1:0] {
        SEL_RATE = 2'd0,
        SEL_CTRL = 2'd1,
        SEL_FLAG = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic pie;
        logic aie;
        logic uie;
        logic sqwe;
    } ctrl_t;

    typedef struct packed {
        logic pf;
        logic af;
        logic uf;
    } flags_t;
endpackage

// File: rtl/prg_divider.sv
module prg_divider
    import prg_pkg::*;
#(
    parameter int RW = RATE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [RW-1:0] rate,
    input  logic          sqw_en,
    output logic          per_edge,
    output logic          sqw
);
    localparam int CW = (1 << RW) - 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } div_state_t;

    div_state_t st_d, st_q;
    logic [CW:0] taps;
    logic [CW:0] lo_mask;
    logic [CW:0] half_pt;
    logic [CW:0] cnt_ext;
    logic        sel_bit;

    // tap 0 is the "off" selection, tap r is counter bit r-1
    assign taps[0] = 1'b0;
    for (genvar r = 1; r <= CW; r++) begin : g_tap
        assign taps[r] = st_q.cnt[r-1];
    end

    always_comb begin
        st_d     = st_q;
        cnt_ext  = {1'b0, st_q.cnt};
        lo_mask  = ((CW+1)'(1) << rate) - (CW+1)'(1);
        half_pt  = ((CW+1)'(1) << rate) >> 1;
        sel_bit  = taps[rate];
        per_edge = 1'b0;
        if (tick) begin
            st_d.cnt = st_q.cnt + CW'(1);
            if (rate != '0 && (cnt_ext & lo_mask) == half_pt - (CW+1)'(1))
                per_edge = 1'b1;
        end
        sqw = sqw_en & sel_bit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(st_q.cnt));
    // R5
    sqw_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sqw_en || rate == '0) |-> !sqw);
    // R6
    edge_rises_chk: assert property (@(posedge clk) disable iff (!rst_n)
        per_edge |=> (sel_bit || !$stable(rate)));
endmodule

// File: rtl/prg_flags.sv
module prg_flags
    import prg_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   per_edge,
    input  logic   alarm_evt,
    input  logic   update_evt,
    input  logic   clr,
    input  ctrl_t  ctrl,
    output flags_t flags,
    output logic   summary
);
    typedef struct packed {
        flags_t fl;
    } flag_state_t;

    flag_state_t st_d, st_q;
    flags_t      set_v;

    always_comb begin
        set_v.pf = per_edge;
        set_v.af = alarm_evt;
        set_v.uf = update_evt;
        st_d     = st_q;
        st_d.fl  = (clr ? '0 : st_q.fl) | set_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags   = st_q.fl;
    assign summary = (st_q.fl.pf & ctrl.pie) | (st_q.fl.af & ctrl.aie) |
                     (st_q.fl.uf & ctrl.uie);

    // R10
    set_survives_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && per_edge) |=> flags.pf);
    // R9
    clr_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !per_edge && !alarm_evt && !update_evt) |=> (flags == '0));
    // R6
    pf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags.pf && !clr) |=> flags.pf);
    // R8
    summary_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        summary |-> (flags != '0));
endmodule

// File: rtl/prg_regs.sv
module prg_regs
    import prg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  sel,
    input  logic              wr,
    input  logic              rd,
    input  logic [DATA_W-1:0] wdata,
    input  flags_t            flags,
    input  logic              summary,
    output logic [RATE_W-1:0] rate,
    output ctrl_t             ctrl,
    output logic [DATA_W-1:0] rdata,
    output logic              clr
);
    typedef struct packed {
        logic [RATE_W-1:0] rate;
        ctrl_t             ctrl;
        logic [DATA_W-1:0] rdata;
    } reg_state_t;

    reg_state_t        st_d, st_q;
    reg_sel_e          sel_e;
    logic [DATA_W-1:0] view;

    always_comb begin
        sel_e = reg_sel_e'(sel);
        st_d  = st_q;
        view  = '0;
        unique case (sel_e)
            SEL_RATE: view[RATE_W-1:0] = st_q.rate;
            SEL_CTRL: begin
                view[CTL_PIE]  = st_q.ctrl.pie;
                view[CTL_AIE]  = st_q.ctrl.aie;
                view[CTL_UIE]  = st_q.ctrl.uie;
                view[CTL_SQWE] = st_q.ctrl.sqwe;
            end
            SEL_FLAG: begin
                view[FLG_SUM] = summary;
                view[FLG_PF]  = flags.pf;
                view[FLG_AF]  = flags.af;
                view[FLG_UF]  = flags.uf;
            end
            default: view = '0;
        endcase
        if (wr) begin
            if (sel_e == SEL_RATE) st_d.rate = wdata[RATE_W-1:0];
            if (sel_e == SEL_CTRL) begin
                st_d.ctrl.pie  = wdata[CTL_PIE];
                st_d.ctrl.aie  = wdata[CTL_AIE];
                st_d.ctrl.uie  = wdata[CTL_UIE];
                st_d.ctrl.sqwe = wdata[CTL_SQWE];
            end
        end
        if (rd) st_d.rdata = view;
        clr = rd && (sel_e == SEL_FLAG);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rate  = st_q.rate;
    assign ctrl  = st_q.ctrl;
    assign rdata = st_q.rdata;

    // R11
    flag_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel == SEL_FLAG) |=> ($stable(rate) && $stable(ctrl)));
    // R2
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(rdata));
endmodule

// File: rtl/periodic_rate_gen.sv
module periodic_rate_gen
    import prg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic              alarm_evt,
    input  logic              update_evt,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              sqw_out,
    output logic              irq_out
);
    logic [RATE_W-1:0] rate;
    ctrl_t             ctrl;
    flags_t            flags;
    logic              summary;
    logic              clr;
    logic              per_edge;

    prg_regs u_regs (
        .clk(clk), .rst_n(rst_n), .sel(reg_sel), .wr(reg_wr), .rd(reg_rd),
        .wdata(reg_wdata), .flags(flags), .summary(summary),
        .rate(rate), .ctrl(ctrl), .rdata(reg_rdata), .clr(clr)
    );

    prg_divider #(.RW(RATE_W)) u_div (
        .clk(clk), .rst_n(rst_n), .tick(ref_tick), .rate(rate),
        .sqw_en(ctrl.sqwe), .per_edge(per_edge), .sqw(sqw_out)
    );

    prg_flags u_flags (
        .clk(clk), .rst_n(rst_n), .per_edge(per_edge), .alarm_evt(alarm_evt),
        .update_evt(update_evt), .clr(clr), .ctrl(ctrl),
        .flags(flags), .summary(summary)
    );

    assign irq_out = summary;

    // R8
    irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.pie && !ctrl.aie && !ctrl.uie) |-> !irq_out);
endmodule

// File: tb/periodic_rate_gen_test.sv
module periodic_rate_gen_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_tick = 1'b0, alarm_evt = 1'b0, update_evt = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       sqw_out, irq_out;

    int n_chk = 0;
    int n_fail = 0;
    logic [14:0] k = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    periodic_rate_gen uut (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .alarm_evt(alarm_evt),
        .update_evt(update_evt), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sqw_out(sqw_out), .irq_out(irq_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic t, input logic r, input logic w,
                        input logic [1:0] s, input logic [7:0] d,
                        input logic al, input logic up);
        ref_tick = t; reg_rd = r; reg_wr = w; reg_sel = s; reg_wdata = d;
        alarm_evt = al; update_evt = up;
        @(negedge clk);
        ref_tick = 0; reg_rd = 0; reg_wr = 0; alarm_evt = 0; update_evt = 0;
        if (t) k = k + 15'd1;
    endtask

    task automatic wr_reg(input logic [1:0] s, input logic [7:0] d);
        step(0, 0, 1, s, d, 0, 0);
    endtask

    task automatic rd_reg(input logic [1:0] s, output logic [7:0] v);
        step(0, 1, 0, s, 8'd0, 0, 0);
        v = reg_rdata;
    endtask

    task automatic tick1();
        step(1, 0, 0, 2'd3, 8'd0, 0, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 sqw", int'(sqw_out), 0);
        chk("R1 irq", int'(irq_out), 0);
        chk("R1 rdata", int'(reg_rdata), 0);
        rd_reg(2'd0, v); chk("R1 rate", int'(v), 0);
        rd_reg(2'd1, v); chk("R1 ctrl", int'(v), 0);
        rd_reg(2'd2, v); chk("R1 flags", int'(v), 0);

        // R2 rate register
        wr_reg(2'd0, 8'hF7);
        rd_reg(2'd0, v); chk("R2 rate readback", int'(v), 'h07);
        step(0, 0, 0, 2'd0, 8'd0, 0, 0);
        chk("R2 rdata held", int'(reg_rdata), 'h07);
        // R3 control register
        wr_reg(2'd1, 8'hFF);
        rd_reg(2'd1, v); chk("R3 ctrl readback", int'(v), 'h78);
        wr_reg(2'd1, 8'h00);
        // R11 writes to flag register ignored
        wr_reg(2'd2, 8'hFF);
        rd_reg(2'd2, v); chk("R11 flags after write", int'(v), 0);
        rd_reg(2'd0, v); chk("R11 rate after write", int'(v), 'h07);
        rd_reg(2'd1, v); chk("R11 ctrl after write", int'(v), 0);

        // R5 square wave off when disabled (rate 7, SQWE=0)
        for (int i = 0; i < 200; i++) begin
            tick1();
            chk("R5 sqw disabled", int'(sqw_out), 0);
        end
        // R6 flag set without periodic enable; irq stays low
        chk("R6 irq gated", int'(irq_out), 0);
        rd_reg(2'd2, v); chk("R6 pf without enable", int'(v), 'h40);
        // R6 exact edge: code 7 edge on tick with k%128==63
        while (k[6:0] != 7'd63) tick1();
        rd_reg(2'd2, v);
        rd_reg(2'd2, v); chk("R6 before edge", int'(v), 0);
        tick1();
        rd_reg(2'd2, v); chk("R6 at edge", int'(v), 'h40);
        // R5 rate 0 with SQWE=1 stays low, no flag
        wr_reg(2'd0, 8'h00);
        wr_reg(2'd1, 8'h08);
        for (int i = 0; i < 64; i++) begin
            tick1();
            chk("R5 rate zero sqw", int'(sqw_out), 0);
        end
        rd_reg(2'd2, v); chk("R6 rate zero no flag", int'(v), 0);

        // R8 periodic interrupt enabled
        wr_reg(2'd0, 8'h03);
        wr_reg(2'd1, 8'h40);
        while (k[2:0] != 3'd3) tick1();
        tick1();
        chk("R8 irq on pf", int'(irq_out), 1);
        rd_reg(2'd2, v); chk("R8 summary pf", int'(v), 'hC0);
        chk("R9 irq after read", int'(irq_out), 0);
        rd_reg(2'd2, v); chk("R9 cleared", int'(v), 0);

        // R7 alarm/update flags
        wr_reg(2'd0, 8'h00);
        wr_reg(2'd1, 8'h30);
        step(0, 0, 0, 2'd3, 8'd0, 1, 0);
        chk("R8 irq alarm", int'(irq_out), 1);
        rd_reg(2'd2, v); chk("R7 alarm flag", int'(v), 'hA0);
        step(0, 0, 0, 2'd3, 8'd0, 0, 1);
        rd_reg(2'd2, v); chk("R7 update flag", int'(v), 'h90);
        wr_reg(2'd1, 8'h00);
        step(0, 0, 0, 2'd3, 8'd0, 1, 1);
        chk("R8 irq disabled", int'(irq_out), 0);
        rd_reg(2'd2, v); chk("R7 both no summary", int'(v), 'h30);

        // R10 flag set in same cycle as read
        wr_reg(2'd0, 8'h01);
        if (k[0]) tick1();
        rd_reg(2'd2, v);
        step(1, 1, 0, 2'd2, 8'd0, 0, 0);
        chk("R10 read during edge", int'(reg_rdata), 0);
        rd_reg(2'd2, v); chk("R10 pf survives", int'(v), 'h40);
        step(0, 1, 0, 2'd2, 8'd0, 1, 0);
        chk("R10 read during alarm", int'(reg_rdata), 0);
        rd_reg(2'd2, v); chk("R10 af survives", int'(v), 'h20);

        // R4 sweep of all rate codes
        wr_reg(2'd1, 8'h08);
        for (int n = 1; n <= 15; n++) begin
            wr_reg(2'd0, 8'(n));
            rd_reg(2'd2, v);
            chk("R4 sqw after select", int'(sqw_out), int'(k[n-1]));
            for (int i = 0; i < (1 << n) + 4; i++) begin
                tick1();
                chk("R4 sqw", int'(sqw_out), int'(k[n-1]));
            end
            rd_reg(2'd2, v); chk("R6 pf per code", int'(v & 8'h40), 'h40);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule